// File: doc/BRIEF.md
# Calibrated RTC Seconds Prescaler

This block turns a 32,768 Hz crystal-domain clock into a seconds pulse, a half-second pulse and a minute pulse for a real-time clock. Crystals drift, so the block accepts a signed 8-bit trim value. Once per minute it stretches or shrinks one second by four crystal cycles per unit of trim, which keeps long-term timekeeping close to ideal while every other second stays nominal.

Software writes the trim through a single strobe. A write is taken only while the timer is stopped, or in the one cycle in which the seconds pulse is high. A write at any other time is dropped. An accepted value sits in a shadow register and becomes active at the next minute boundary. The corrected second is always the first second of a minute, and every pulse output lasts one clock cycle.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: While reset is asserted and after it is released, all pulse outputs and `cal_ack` stay low until the timer is enabled. The trim in use after reset is zero, so the first second lasts exactly NOMINAL_COUNT enabled cycles.
- R2: Every second other than the first of a minute lasts exactly NOMINAL_COUNT enabled cycles, whatever the trim value.
- R3: The first second of each minute lasts NOMINAL_COUNT − 4·trim enabled cycles. A positive trim shortens that second, which adds pulses for a slow crystal.
- R4: A negative trim lengthens the first second. Trim 0x80 (−128) gives NOMINAL_COUNT + 512 cycles and trim 0x7F (+127) gives NOMINAL_COUNT − 508 cycles.
- R5: `min_tick` pulses together with the `sec_tick` that ends the last second of each minute (second index SECONDS_PER_MIN − 1), and at no other time.
- R6: `half_tick` pulses floor(L/2) enabled cycles into a second of length L. In the default mode it also pulses with every `sec_tick`.
- R7: A write is accepted when `cal_wr` is high while `en` is low, or while `sec_tick` is high. `cal_ack` is high in the cycle after an accepted write.
- R8: A write outside that window is ignored: `cal_ack` stays low and the trim applied at the following minute is unchanged.
- R9: An accepted trim takes effect from the next minute boundary. A write accepted in the cycle where `min_tick` is high does not alter the second then starting; it first applies one minute later.
- R10: While `en` is low the count holds and no pulse is produced. After `en` returns high the second resumes and still totals its full enabled length.
- R11: Every pulse output (`sec_tick`, `half_tick`, `min_tick`, `cal_ack`) is high for a single cycle at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Timer run enable; low freezes the prescaler |
| cal_val | input | CAL_W | Signed two's-complement trim value |
| cal_wr | input | 1 | Write strobe for `cal_val` |
| half_tick | output | 1 | Half-second pulse |
| sec_tick | output | 1 | Seconds pulse |
| min_tick | output | 1 | Minute pulse |
| cal_ack | output | 1 | High the cycle after a trim write is accepted |

## Verification
Two events can fall in the same cycle: a trim write accepted in its window, and the minute rollover that copies the shadow trim into the active one. The write window opens in the cycle in which `sec_tick` and `min_tick` are both high. At that point the rollover has just moved the old shadow value into use for the correction second now starting. The bench writes a new trim in exactly that cycle. It expects an acknowledge, an unchanged correction second for the current minute, and the new length only in the first second of the minute after.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   // Selects which events drive the half-second output
   typedef enum logic {
      HALF_MID_ONLY    = 1'b0,
      HALF_MID_AND_END = 1'b1
   } half_mode_e;

endpackage

// File: rtl/rtc_trim_regs.sv
module rtc_trim_regs #(
   parameter int CAL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             sec_tick,
   input  logic             cal_wr,
   input  logic [CAL_W-1:0] cal_val,
   input  logic             min_wrap,
   output logic [CAL_W-1:0] cal_active,
   output logic             cal_ack
);

   logic [CAL_W-1:0] shadow_q;
   logic             wr_ok;

   // window: timer stopped, or the cycle the seconds pulse is high
   assign wr_ok = cal_wr && (!en || sec_tick);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q   <= '0;
         cal_active <= '0;
         cal_ack    <= 1'b0;
      end else begin
         cal_ack <= wr_ok;
         if (wr_ok)
            shadow_q <= cal_val;
         if (min_wrap)
            cal_active <= shadow_q;
      end
   end

   AST_ACK_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      cal_ack |-> ($past(cal_wr) && (!$past(en) || $past(sec_tick)))); // R7

   AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_ack && !cal_wr) |=> !cal_ack); // R11

endmodule

// File: rtl/rtc_min_ctr.sv
module rtc_min_ctr #(
   parameter int SECONDS_PER_MIN = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_wrap,
   output logic corr_sec,
   output logic min_wrap,
   output logic min_tick
);

   localparam int SW = (SECONDS_PER_MIN > 2) ? $clog2(SECONDS_PER_MIN) : 1;
   localparam logic [SW-1:0] LAST_SEC = SW'(SECONDS_PER_MIN - 1);

   logic [SW-1:0] sec_idx;

   assign corr_sec = (sec_idx == '0);
   assign min_wrap = sec_wrap && (sec_idx == LAST_SEC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_idx  <= '0;
         min_tick <= 1'b0;
      end else begin
         min_tick <= min_wrap;
         if (min_wrap)
            sec_idx <= '0;
         else if (sec_wrap)
            sec_idx <= sec_idx + 1'b1;
      end
   end

   AST_MIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      min_tick |=> !min_tick); // R11

   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      sec_idx <= LAST_SEC); // R5

endmodule

// File: rtl/rtc_sec_div.sv
module rtc_sec_div
   import rtc_cal_pkg::*;
#(
   parameter int         NOMINAL_COUNT = 32768,
   parameter int         CAL_W         = 8,
   parameter int         CAL_SCALE     = 4,
   parameter int         CNT_W         = 16,
   parameter half_mode_e HALF_MODE     = HALF_MID_AND_END
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             corr_sec,
   input  logic [CAL_W-1:0] cal_active,
   output logic             sec_wrap,
   output logic             half_tick,
   output logic             sec_tick
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cal_ext;
   logic [CNT_W-1:0] term;
   logic [CNT_W-1:0] half_pt;
   logic             mid_hit;
   logic             half_src;

   // sign-extend, then scale; arithmetic wraps modulo 2^CNT_W into a positive length
   assign cal_ext = {{(CNT_W-CAL_W){cal_active[CAL_W-1]}}, cal_active};
   assign term    = corr_sec ? (CNT_W'(NOMINAL_COUNT) - CNT_W'(CAL_SCALE) * cal_ext)
                             : CNT_W'(NOMINAL_COUNT);
   assign half_pt = (term >> 1) - 1'b1;

   assign sec_wrap = en && (cnt == term - 1'b1);
   assign mid_hit  = en && (cnt == half_pt);

   generate
      if (HALF_MODE == HALF_MID_AND_END) begin : g_half_both
         assign half_src = mid_hit || sec_wrap;
      end else begin : g_half_mid
         assign half_src = mid_hit;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         sec_tick  <= 1'b0;
         half_tick <= 1'b0;
      end else begin
         sec_tick  <= sec_wrap;
         half_tick <= half_src;
         if (sec_wrap)
            cnt <= '0;
         else if (en)
            cnt <= cnt + 1'b1;
      end
   end

   AST_CNT_BELOW_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < term); // R3

   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!sec_tick && !half_tick)); // R10

   AST_SEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick); // R11

endmodule

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler
   import rtc_cal_pkg::*;
#(
   parameter int         NOMINAL_COUNT   = 32768,
   parameter int         CAL_W           = 8,
   parameter int         CAL_SCALE       = 4,
   parameter int         SECONDS_PER_MIN = 60,
   parameter half_mode_e HALF_MODE       = HALF_MID_AND_END
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CAL_W-1:0] cal_val,
   input  logic             cal_wr,
   output logic             half_tick,
   output logic             sec_tick,
   output logic             min_tick,
   output logic             cal_ack
);

   localparam int MAX_CORR = CAL_SCALE * (2 ** (CAL_W - 1));
   localparam int CNT_W    = $clog2(NOMINAL_COUNT + MAX_CORR + 1);

   // elaboration-time parameter checks
   if (NOMINAL_COUNT <= MAX_CORR + 2) begin : g_chk_nom
      $error("NOMINAL_COUNT too small for the trim range");
   end
   if (SECONDS_PER_MIN < 2) begin : g_chk_spm
      $error("SECONDS_PER_MIN must be at least 2");
   end
   if (CNT_W <= CAL_W) begin : g_chk_w
      $error("counter width must exceed trim width");
   end

   logic [CAL_W-1:0] cal_active;
   logic             sec_wrap;
   logic             min_wrap;
   logic             corr_sec;

   rtc_trim_regs #(
      .CAL_W (CAL_W)
   ) u_trim (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .sec_tick   (sec_tick),
      .cal_wr     (cal_wr),
      .cal_val    (cal_val),
      .min_wrap   (min_wrap),
      .cal_active (cal_active),
      .cal_ack    (cal_ack)
   );

   rtc_sec_div #(
      .NOMINAL_COUNT (NOMINAL_COUNT),
      .CAL_W         (CAL_W),
      .CAL_SCALE     (CAL_SCALE),
      .CNT_W         (CNT_W),
      .HALF_MODE     (HALF_MODE)
   ) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .corr_sec   (corr_sec),
      .cal_active (cal_active),
      .sec_wrap   (sec_wrap),
      .half_tick  (half_tick),
      .sec_tick   (sec_tick)
   );

   rtc_min_ctr #(
      .SECONDS_PER_MIN (SECONDS_PER_MIN)
   ) u_min (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_wrap (sec_wrap),
      .corr_sec (corr_sec),
      .min_wrap (min_wrap),
      .min_tick (min_tick)
   );

   AST_MIN_WITH_SEC: assert property (@(posedge clk) disable iff (!rst_n)
      min_tick |-> sec_tick); // R5

   generate
      if (HALF_MODE == HALF_MID_AND_END) begin : g_ast_half
         AST_HALF_WITH_SEC: assert property (@(posedge clk) disable iff (!rst_n)
            sec_tick |-> half_tick); // R6
      end
   endgenerate

endmodule

// File: tb/test_rtc_cal_prescaler.sv
`timescale 1ns/1ps
module test_rtc_cal_prescaler;
   import rtc_cal_pkg::*;

   localparam int NOM = 1024;
   localparam int SPM = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] cal_val = '0;
   logic       cal_wr = 1'b0;
   logic       half_tick, sec_tick, min_tick, cal_ack;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // bench reference model of the trim and second index
   int m_idx    = 0;
   int m_active = 0;
   int m_shadow = 0;
   bit m_first  = 1'b1;

   always #5 clk = ~clk;

   rtc_cal_prescaler #(
      .NOMINAL_COUNT   (NOM),
      .CAL_W           (8),
      .CAL_SCALE       (4),
      .SECONDS_PER_MIN (SPM),
      .HALF_MODE       (HALF_MID_AND_END)
   ) i_rtc_cal_prescaler (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .cal_val   (cal_val),
      .cal_wr    (cal_wr),
      .half_tick (half_tick),
      .sec_tick  (sec_tick),
      .min_tick  (min_tick),
      .cal_ack   (cal_ack)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Runs one second; optional write at active cycle wr_at, optional pause with a write inside
   task automatic measure_second(input int wr_at, input logic [7:0] wv,
                                 input int pause_at, input int pause_len,
                                 input bit pause_wr, input logic [7:0] pwv,
                                 input string len_req, input string wr_req);
      int  exp_len, n, half_at;
      bit  exp_acc;
      exp_len = (m_idx == 0) ? NOM - 4 * m_active : NOM;
      n = 0;
      half_at = -1;
      exp_acc = 1'b0;
      while (1) begin
         if (n == pause_at) begin
            en = 1'b0;
            for (int p = 0; p < pause_len; p++) begin
               if (pause_wr && p == 5) begin
                  cal_val = pwv;
                  cal_wr  = 1'b1;
               end
               @(posedge clk); #1;
               if (cal_wr) begin
                  cal_wr = 1'b0;
                  check(cal_ack == 1'b1, "R7 ack while stopped", cal_ack, 1);
                  m_shadow = $signed(pwv);
               end
               check(!sec_tick && !half_tick, "R10 no pulse while stopped",
                     {sec_tick, half_tick}, 0);
            end
            en = 1'b1;
         end
         if (n == wr_at) begin
            cal_val = wv;
            cal_wr  = 1'b1;
            exp_acc = (n == 0) && !m_first;
         end
         @(posedge clk); #1;
         n++;
         if (cal_wr) begin
            cal_wr = 1'b0;
            check(cal_ack == exp_acc, wr_req, cal_ack, exp_acc);
            if (exp_acc) m_shadow = $signed(wv);
         end
         if (n == 1 && !m_first)
            check(!sec_tick && !min_tick, "R11 single-cycle pulse", {sec_tick, min_tick}, 0);
         if (half_tick && !sec_tick) half_at = n;
         if (sec_tick) break;
         if (n > 4000) break;
      end
      check(n == exp_len, len_req, n, exp_len);
      check(half_at == exp_len / 2, "R6 half-second position", half_at, exp_len / 2);
      check(half_tick == 1'b1, "R6 half pulse with second", half_tick, 1);
      check(min_tick == (m_idx == SPM - 1), "R5 minute pulse", min_tick, (m_idx == SPM - 1));
      if (m_idx == SPM - 1) m_active = m_shadow;
      m_idx = (m_idx + 1) % SPM;
      m_first = 1'b0;
   endtask

   task automatic plain_second(input string req);
      measure_second(-1, 8'h00, -1, 0, 1'b0, 8'h00, req, "");
   endtask

   task automatic t_reset();
      repeat (3) @(posedge clk);
      #1;
      check(!half_tick && !sec_tick && !min_tick && !cal_ack, "R1 outputs in reset",
            {half_tick, sec_tick, min_tick, cal_ack}, 0);
      rst_n = 1'b1;
      repeat (6) @(posedge clk);
      #1;
      check(!half_tick && !sec_tick && !min_tick && !cal_ack, "R1 idle after reset",
            {half_tick, sec_tick, min_tick, cal_ack}, 0);
      en = 1'b1;
      plain_second("R1 first second length");
   endtask

   task automatic t_plain_minute();
      plain_second("R2 plain second");
      plain_second("R2 plain second");
      plain_second("R2 last second of minute");
   endtask

   task automatic t_collide_write();
      // write in the cycle where min_tick and sec_tick are high: R9
      measure_second(0, 8'd25, -1, 0, 1'b0, 8'h00, "R9 current corr second unchanged",
                     "R7 ack in seconds window");
      measure_second(100, 8'h05, -1, 0, 1'b0, 8'h00, "R2 second with ignored write",
                     "R8 write outside window not acked");
      plain_second("R2 plain second");
      plain_second("R2 plain second");
   endtask

   task automatic t_positive_trim();
      // +25 -> 924 cycles; also queue -128
      measure_second(0, 8'h80, -1, 0, 1'b0, 8'h00, "R3 shortened corr second (R8 kept prior)",
                     "R7 ack in seconds window");
      plain_second("R2 plain second with trim");
      plain_second("R2 plain second with trim");
      plain_second("R2 plain second with trim");
   endtask

   task automatic t_negative_trim();
      measure_second(-1, 8'h00, -1, 0, 1'b0, 8'h00, "R4 trim -128 lengthens", "");
      measure_second(-1, 8'h00, 100, 50, 1'b1, 8'h7F, "R10 paused second total", "");
      plain_second("R2 plain second");
      plain_second("R2 plain second");
   endtask

   task automatic t_max_positive();
      measure_second(-1, 8'h00, -1, 0, 1'b0, 8'h00, "R4 trim +127 shortens", "");
      measure_second(0, 8'h00, -1, 0, 1'b0, 8'h00, "R2 plain second", "R7 ack in seconds window");
      plain_second("R2 plain second");
      plain_second("R2 plain second");
      plain_second("R3 zero trim restores nominal");
   endtask

   initial begin
      t_reset();
      t_plain_minute();
      t_collide_write();
      t_positive_trim();
      t_negative_trim();
      t_max_positive();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule